// File: doc/BRIEF.md
# Device Checksum Accumulator

This block folds a stream of memory words into the 16-bit checksum that a device programmer reports for a part. A start pulse opens a calculation and samples the code-protect flag. The block then takes a fixed sequence of 14-bit words, one per cycle in which the valid input is high. The sequence is every program word from address 0x000 up to 0xFFF, then configuration word 1, then configuration word 2, then ID words 0 to 3. After the last ID word it raises a one-cycle done strobe, and the checksum output holds the result.

With protection off, the result is the program words plus both masked configuration words. With protection on, the program words still stream through but add nothing. In their place the block adds a 16-bit value built from the low nibble of each ID word. Every addition wraps modulo 2^16. Words that arrive while no calculation is open are ignored. A fresh start pulse abandons any calculation in progress and begins again from zero.

Top module: `csum_accum`

## Requirements
- R1: A start pulse clears the running checksum to 0 on the next cycle. It opens a calculation that accepts, on each cycle with wordValid high, words in this fixed order: PROG_WORDS (default 4096) program words, configuration word 1, configuration word 2, ID word 0, ID word 1, ID word 2, ID word 3.
- R2: With protection off, the checksum is the sum of all program words (zero-extended from 14 to 16 bits), plus (config1 AND 0x3FFF), plus (config2 AND 0x0003).
- R3: With protection on, program words add nothing. The checksum is (config1 AND 0x3FFF) + (config2 AND 0x0003) + the packed ID value.
- R4: The packed ID value is made of bits 3:0 of each ID word, with ID word 0 in bits 15:12 and ID word 3 in bits 3:0. For example, IDs 1, 2, 3, 4 give 0x1234.
- R5: All sums keep only their low 16 bits. A blank device, with every word 0x3FFF and protection off, gives 0x3002.
- R6: done is high for exactly one cycle, namely the cycle after the clock edge that accepts ID word 3. In that cycle checksum carries the final result, and it holds that value until the next start pulse.
- R7: Words presented before the first start pulse, or after done, are ignored. checksum does not change, and done stays low.
- R8: A start pulse during a calculation restarts it from zero. A word that is valid in the same cycle as start is not accepted.
- R9: codeProtect is sampled only in the start cycle. Changing it later during the calculation has no effect.
- R10: After reset, done is 0 and checksum is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Single-cycle pulse that opens a new calculation |
| codeProtect | input | 1 | Code-protect flag, sampled with start |
| wordValid | input | 1 | wordData carries the next word of the sequence |
| wordData | input | WORD_W (14) | Program, configuration or ID word |
| checksum | output | SUM_W (16) | Running checksum; the final result while done is high and afterwards |
| done | output | 1 | One-cycle strobe marking the end of the calculation |

## Verification
Each accepted word reaches checksum through one register. So after the edge that takes a word, its contribution is visible in the same cycle that done would rise. A start pulse shows as a zero checksum one cycle later. The bench drives inputs on falling edges. At each rising edge a behavioural model advances on the same inputs, and on the next falling edge the model's running sum and done flag are compared with the outputs. In this way every word, restart and ignored word is checked exactly one cycle after its edge. Fixed expected results for blank, protected and patterned devices are also checked in the cycle done is due, and again after stray words that follow it.

// File: rtl/csum_pkg.sv
package csum_pkg;

  // Stage of the fixed word sequence the control expects next
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_PROG,
    PH_CFG1,
    PH_CFG2,
    PH_ID
  } phase_t;

  // Strobes from control to datapath, valid for one cycle
  typedef struct packed {
    logic clear;    // start: zero the sums and sample protection
    logic addProg;  // program word accepted
    logic addCfg1;  // configuration word 1 accepted
    logic addCfg2;  // configuration word 2 accepted
    logic addId;    // an ID word accepted
  } dpStrobe_t;

endpackage

// File: rtl/csum_ctrl.sv
module csum_ctrl
  import csum_pkg::*;
#(
  parameter int PROG_WORDS = 4096,
  parameter int ID_WORDS   = 4
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      wordValid,
  output dpStrobe_t strobe,
  output logic      busy,
  output logic      done
);

  localparam int PROG_CNT_W = (PROG_WORDS > 1) ? $clog2(PROG_WORDS) : 1;
  localparam int ID_CNT_W   = (ID_WORDS > 1) ? $clog2(ID_WORDS) : 1;
  localparam logic [PROG_CNT_W-1:0] PROG_LAST = PROG_CNT_W'(PROG_WORDS - 1);
  localparam logic [ID_CNT_W-1:0]   ID_LAST   = ID_CNT_W'(ID_WORDS - 1);

  phase_t                phase;
  logic [PROG_CNT_W-1:0] progCnt;
  logic [ID_CNT_W-1:0]   idCnt;
  logic                  accept;
  logic                  finish;

  assign busy   = (phase != PH_IDLE);
  // start has priority: a word valid in the start cycle is dropped
  assign accept = wordValid && busy && !start;
  assign finish = accept && (phase == PH_ID) && (idCnt == ID_LAST);

  always_comb begin
    strobe         = '0;
    strobe.clear   = start;
    strobe.addProg = accept && (phase == PH_PROG);
    strobe.addCfg1 = accept && (phase == PH_CFG1);
    strobe.addCfg2 = accept && (phase == PH_CFG2);
    strobe.addId   = accept && (phase == PH_ID);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      progCnt <= '0;
      idCnt   <= '0;
      done    <= 1'b0;
    end else begin
      done <= finish;
      if (start) begin
        phase   <= PH_PROG;
        progCnt <= '0;
        idCnt   <= '0;
      end else if (accept) begin
        unique case (phase)
          PH_PROG: begin
            progCnt <= progCnt + 1'b1;
            if (progCnt == PROG_LAST) phase <= PH_CFG1;
          end
          PH_CFG1: phase <= PH_CFG2;
          PH_CFG2: phase <= PH_ID;
          PH_ID: begin
            idCnt <= idCnt + 1'b1;
            if (idCnt == ID_LAST) phase <= PH_IDLE;
          end
          default: phase <= PH_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/csum_datapath.sv
module csum_datapath
  import csum_pkg::*;
#(
  parameter int                WORD_W    = 14,
  parameter int                SUM_W     = 16,
  parameter int                ID_WORDS  = 4,
  parameter logic [WORD_W-1:0] CFG1_MASK = 14'h3FFF,
  parameter logic [WORD_W-1:0] CFG2_MASK = 14'h0003
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic              codeProtect,
  input  logic [WORD_W-1:0] wordData,
  output logic              protOn,
  output logic [SUM_W-1:0]  checksum
);

  localparam int NIB_W = SUM_W / ID_WORDS;

  logic [SUM_W-1:0] acc;     // program and configuration contributions
  logic [SUM_W-1:0] idPack;  // ID nibbles, first ID ends up most significant
  logic [SUM_W-1:0] addend;
  logic             protQ;

  always_comb begin
    addend = '0;
    if (strobe.addProg && !protQ) addend = SUM_W'(wordData);
    if (strobe.addCfg1)           addend = SUM_W'(wordData & CFG1_MASK);
    if (strobe.addCfg2)           addend = SUM_W'(wordData & CFG2_MASK);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc    <= '0;
      idPack <= '0;
      protQ  <= 1'b0;
    end else if (strobe.clear) begin
      acc    <= '0;
      idPack <= '0;
      protQ  <= codeProtect;
    end else begin
      acc <= acc + addend;
      if (strobe.addId)
        idPack <= {idPack[SUM_W-NIB_W-1:0], wordData[NIB_W-1:0]};
    end
  end

  assign protOn   = protQ;
  assign checksum = acc + (protQ ? idPack : '0);

endmodule

// File: rtl/csum_accum.sv
module csum_accum
  import csum_pkg::*;
#(
  parameter int                PROG_WORDS = 4096,
  parameter int                WORD_W     = 14,
  parameter int                SUM_W      = 16,
  parameter int                ID_WORDS   = 4,
  parameter logic [WORD_W-1:0] CFG1_MASK  = 14'h3FFF,
  parameter logic [WORD_W-1:0] CFG2_MASK  = 14'h0003
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              codeProtect,
  input  logic              wordValid,
  input  logic [WORD_W-1:0] wordData,
  output logic [SUM_W-1:0]  checksum,
  output logic              done
);

  dpStrobe_t strobe;
  logic      busy;
  logic      protOn;

  csum_ctrl #(
    .PROG_WORDS(PROG_WORDS),
    .ID_WORDS  (ID_WORDS)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .wordValid(wordValid),
    .strobe   (strobe),
    .busy     (busy),
    .done     (done)
  );

  csum_datapath #(
    .WORD_W   (WORD_W),
    .SUM_W    (SUM_W),
    .ID_WORDS (ID_WORDS),
    .CFG1_MASK(CFG1_MASK),
    .CFG2_MASK(CFG2_MASK)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .codeProtect(codeProtect),
    .wordData   (wordData),
    .protOn     (protOn),
    .checksum   (checksum)
  );

endmodule

// File: rtl/csum_accum_chk.sv
module csum_accum_chk #(
  parameter int SUM_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic             done,
  input logic             busy,
  input logic             protOn,
  input logic             addProg,
  input logic [SUM_W-1:0] checksum
);

  // R1 / R8: a start pulse leaves a zero sum and no done behind it
  p_start_clears_r1: assert property (@(posedge clk) disable iff (!rstN)
    start |=> (checksum == '0) && !done);

  // R6: done lasts a single cycle
  p_done_single_r6: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R6: done only follows a cycle in which a calculation was open
  p_done_after_busy_r6: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(busy));

  // R7: with no calculation open and no start, the result holds
  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> $stable(checksum));

  // R3: a program word under protection leaves the sum untouched
  p_prot_prog_r3: assert property (@(posedge clk) disable iff (!rstN)
    (protOn && addProg && !start) |=> $stable(checksum));

endmodule

bind csum_accum csum_accum_chk #(.SUM_W(SUM_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .start   (start),
  .done    (done),
  .busy    (busy),
  .protOn  (protOn),
  .addProg (strobe.addProg),
  .checksum(checksum)
);

// File: tb/csum_accum_bench.sv
module csum_accum_bench;

  localparam int PROG = 4096;
  localparam int SEQ  = PROG + 6;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        codeProtect = 1'b0;
  logic        wordValid = 1'b0;
  logic [13:0] wordData = '0;
  logic [15:0] checksum;
  logic        done;

  int    checks = 0;
  int    failures = 0;
  int    cycles = 0;
  string curReq = "R10";

  // behavioural reference state
  bit mBusy = 0;
  bit mProt = 0;
  bit expDone = 0;
  int mPos = 0;
  int mSum = 0;
  int mId = 0;

  csum_accum u_csum_accum (
    .clk(clk), .rstN(rstN), .start(start), .codeProtect(codeProtect),
    .wordValid(wordValid), .wordData(wordData),
    .checksum(checksum), .done(done)
  );

  always #5 clk = ~clk;

  function automatic int modelValue();
    return (mSum + (mProt ? mId : 0)) & 16'hFFFF;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  // reference model advances on the same edge as the design
  always @(posedge clk) begin
    cycles++;
    expDone = 0;
    if (!rstN) begin
      mBusy = 0; mProt = 0; mPos = 0; mSum = 0; mId = 0;
    end else if (start) begin
      mBusy = 1; mProt = codeProtect; mPos = 0; mSum = 0; mId = 0;
    end else if (wordValid && mBusy) begin
      if (mPos < PROG) begin
        if (!mProt) mSum = mSum + int'(wordData);
      end else if (mPos == PROG) mSum = mSum + (int'(wordData) & 'h3FFF);
      else if (mPos == PROG + 1) mSum = mSum + (int'(wordData) & 'h3);
      else mId = ((mId << 4) | (int'(wordData) & 'hF)) & 'hFFFF;
      mPos++;
      if (mPos == SEQ) begin
        mBusy = 0;
        expDone = 1;
      end
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      check({curReq, " done"}, int'(done), int'(expDone));
      check({curReq, " sum"}, int'(checksum), modelValue());
    end
  end

  initial begin
    wait (cycles > 150000);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  function automatic logic [13:0] progWord(input int kind, input int i, input int seed);
    if (kind == 0) return 14'h3FFF;
    return 14'((i * 37 + seed * 11 + (i >> 3)) & 'h3FFF);
  endfunction

  function automatic logic [13:0] idWord(input int base, input int k);
    return 14'h3FF0 | 14'((base + k) & 'hF);
  endfunction

  // closed-form expectation computed straight from R2..R5
  function automatic int expected(input bit cp, input int kind, input int seed,
                                  input int c1, input int c2, input int idBase);
    int s = 0;
    int p = 0;
    if (!cp) for (int i = 0; i < PROG; i++) s += int'(progWord(kind, i, seed));
    for (int k = 0; k < 4; k++) p = (p << 4) | ((idBase + k) & 'hF);
    s += (c1 & 'h3FFF) + (c2 & 'h3);
    if (cp) s += p;
    return s & 'hFFFF;
  endfunction

  task automatic sendWord(input logic [13:0] w, input int gap);
    repeat (gap) @(negedge clk);
    wordValid = 1'b1;
    wordData  = w;
    @(negedge clk);
    wordValid = 1'b0;
  endtask

  task automatic pulseStart(input bit cp);
    @(negedge clk);
    start = 1'b1;
    codeProtect = cp;
    @(negedge clk);
    start = 1'b0;
    codeProtect = !cp;  // R9: later changes must not matter
  endtask

  task automatic feed(input int kind, input int seed, input int c1,
                      input int c2, input int idBase, input bit gaps);
    for (int i = 0; i < PROG; i++) sendWord(progWord(kind, i, seed), (gaps && i % 7 == 0) ? 1 : 0);
    sendWord(14'(c1), 0);
    sendWord(14'(c2), gaps ? 2 : 0);
    for (int k = 0; k < 4; k++) sendWord(idWord(idBase, k), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    curReq = "R10";
    check("R10 reset done", int'(done), 0);
    check("R10 reset sum", int'(checksum), 0);
    rstN = 1'b1;

    // R7: words before any start
    curReq = "R7";
    for (int i = 0; i < 5; i++) sendWord(14'h1234 + 14'(i), 0);
    check("R7 pre-start sum", int'(checksum), 0);

    // R5 / R2: blank device, protection off
    curReq = "R5";
    pulseStart(1'b0);
    check("R1 cleared", int'(checksum), 0);
    feed(0, 0, 'h3FFF, 'h3FFF, 15, 1'b0);
    check("R6 done at end", int'(done), 1);
    check("R5 blank unprotected", int'(checksum), 'h3002);

    // R7: words after done
    curReq = "R7";
    for (int i = 0; i < 3; i++) sendWord(14'h0ABC, 0);
    check("R7 post-done sum", int'(checksum), 'h3002);
    check("R7 post-done done", int'(done), 0);

    // R3 / R4 / R9: protected, IDs 1..4, protection input dropped after start
    curReq = "R3";
    pulseStart(1'b1);
    feed(0, 0, 'h3FFF, 'h3FFF, 1, 1'b0);
    check("R4 protected packed ids", int'(checksum), 'h5236);
    check("R9 protect sampled", int'(checksum), expected(1'b1, 0, 0, 'h3FFF, 'h3FFF, 1));

    // R2: patterned words with gaps, config2 masked
    curReq = "R2";
    pulseStart(1'b0);
    feed(1, 3, 'h2A5C, 'h3FFE, 10, 1'b1);
    check("R2 patterned", int'(checksum), expected(1'b0, 1, 3, 'h2A5C, 'h3FFE, 10));

    // R8: restart mid-run, word in start cycle dropped
    curReq = "R8";
    pulseStart(1'b0);
    for (int i = 0; i < 100; i++) sendWord(14'h2222, 0);
    @(negedge clk);
    start = 1'b1;
    codeProtect = 1'b1;
    wordValid = 1'b1;
    wordData = 14'h1111;
    @(negedge clk);
    start = 1'b0;
    wordValid = 1'b0;
    codeProtect = 1'b0;
    check("R8 restart cleared", int'(checksum), 0);
    feed(1, 9, 'h1F0F, 'h0001, 6, 1'b0);
    check("R8 restarted result", int'(checksum), expected(1'b1, 1, 9, 'h1F0F, 'h0001, 6));

    // R2 again under protection off with different seed
    curReq = "R2";
    pulseStart(1'b0);
    feed(1, 21, 'h0000, 'h0002, 0, 1'b1);
    check("R2 second pattern", int'(checksum), expected(1'b0, 1, 21, 'h0000, 'h0002, 0));

    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule